// File: doc/BRIEF.md
# PCI Host Configuration Address Translator

This block is the CPU-facing front end of a PCI host bridge. It sorts each CPU access into one of four address windows: bridge control registers, the configuration-address register, PCI I/O port space and the configuration data window. Accesses to the I/O window are passed on with a 16-bit port number. Accesses to the data window are passed on with a window offset, but only once configuration has been enabled. The control registers exist only as placeholders and read back zero.

The configuration-address register converts between two forms. Software writes a device select as a single set bit. The register stores that as a compact bus/devfn/register form with an enable flag. A read turns the stored form back into the one-hot layout. Separately, a small combinational mapper gives the interrupt line number that a device pin drives, on the primary bus and on the secondary buses.

Requests are single-cycle. All outputs toward the CPU and toward the forward paths are registered, one cycle after the request.

Top module: `pcihost_cfg_front`

## Requirements
- R1: After a synchronous active-low reset, `cfg_addr` is zero and `rd_valid`, `io_valid` and `mem_valid` are low.
- R2: A write to the configuration-address window stores a value with bit 16 set. The stored value also holds the written bits 10..2 and the select index `i` shifted left by 11. Bits 1..0 store zero. The stored value appears on `cfg_addr` one cycle after the request.
- R3: The select index `i` is the position of the lowest set bit of the written value, searching bits 11 through 31. When none of these bits is set, `i` is 32.
- R4: A read of the configuration-address window returns the following, OR-ed together: a one at bit `devfn[7:3]`, the value `devfn[2:0]` placed in bits 10..8, and stored bits 7..2. Here `devfn` is stored bits 15..8.
- R5: Byte (size 0), halfword (size 1) and word (size 2) accesses to the configuration-address register all write the full 32-bit value and read the full word.
- R6: Control-window accesses (SPECIAL_BASE+0x2000, 0x40 bytes) read zero, give no forward strobe and leave `cfg_addr` unchanged.
- R7: The windows are as follows. Control is at SPECIAL_BASE+0x2000 (0x40 bytes). Configuration address is at SPECIAL_BASE+0x1000000 (0x10 bytes). I/O is at SPECIAL_BASE+0x2000000 (0x10000 bytes). Data is at MEM_BASE (2^MEM_OFF_W bytes). The first byte past each window is outside it.
- R8: An I/O-window access raises `io_valid` for one cycle. `io_port` carries the low 16 address bits, and the access's write flag, size code and write data are passed along with it.
- R9: A data-window access raises `mem_valid` with `mem_offset` = address − MEM_BASE, but only while `cfg_addr[16]` is set. Otherwise it gives no strobe and reads zero.
- R10: An address outside every window gives no strobe, no change to `cfg_addr`, and reads zero.
- R11: Every read request gives `rd_valid` high for exactly the following cycle. Reads forwarded to the I/O or data window return `fwd_rdata` in that cycle.
- R12: `irq_sec_idx` equals `(irq_devfn & 0x18) >> 1` plus `irq_pin`.
- R13: `irq_pri_idx` equals `irq_pin` plus 16 when `irq_devfn[0]` is set, and `irq_pin` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Single-cycle CPU request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | CPU physical address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| cfg_addr | output | 32 | Stored configuration-address value |
| io_valid | output | 1 | I/O forward strobe |
| io_write | output | 1 | I/O forward direction |
| io_size | output | 2 | I/O forward size |
| io_port | output | 16 | I/O port number |
| io_wdata | output | 32 | I/O write data |
| mem_valid | output | 1 | Data-window forward strobe |
| mem_write | output | 1 | Data-window forward direction |
| mem_size | output | 2 | Data-window forward size |
| mem_offset | output | MEM_OFF_W | Offset into data window |
| mem_wdata | output | 32 | Data-window write data |
| fwd_rdata | input | 32 | Read data returned by the forward target in the strobe cycle |
| irq_devfn | input | 8 | Device/function of interrupting device |
| irq_pin | input | 2 | Interrupt pin 0..3 |
| irq_pri_idx | output | 5 | Primary-bus interrupt line |
| irq_sec_idx | output | 5 | Secondary-bus interrupt line |

## Verification
The assertions assume the following:
- Requests last one cycle and do not overlap.
- The four windows are disjoint, and the I/O window starts on a 64 KiB boundary, so its low 16 address bits equal its offset.
- `irq_pin` stays within 0..3.

The stimulus issues each request for exactly one cycle, with an idle cycle after it. It draws addresses either inside a chosen window or at random across the full address space. It keeps the window parameters at their disjoint, aligned defaults.

// File: rtl/pcihost_pkg.sv
// Shared types and window constants for the PCI host configuration front end.
// Assumes window offsets below are relative to the SPECIAL_BASE parameter.
package pcihost_pkg;

    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_CTRL = 3'd1,
        WIN_CFGA = 3'd2,
        WIN_IO   = 3'd3,
        WIN_MEM  = 3'd4
    } win_e;

    localparam int unsigned NUM_WIN = 4;

    localparam logic [63:0] CTRL_OFS  = 64'h0000_2000;
    localparam logic [63:0] CTRL_SPAN = 64'h0000_0040;
    localparam logic [63:0] CFGA_OFS  = 64'h0100_0000;
    localparam logic [63:0] CFGA_SPAN = 64'h0000_0010;
    localparam logic [63:0] IO_OFS    = 64'h0200_0000;
    localparam logic [63:0] IO_SPAN   = 64'h0001_0000;

    localparam int unsigned SEL_LO  = 11;
    localparam int unsigned EN_BIT  = 16;
    localparam logic [31:0] REG_MASK = 32'h0000_07FC;

endpackage

// File: rtl/pcihost_win_decode.sv
// Window decoder: classifies a CPU address into one of four windows and
// returns the offset inside the hit window. Assumes windows do not overlap.
module pcihost_win_decode
    import pcihost_pkg::*;
#(
    parameter int unsigned ADDR_W       = 36,
    parameter logic [63:0] SPECIAL_BASE = 64'h1_FE00_0000,
    parameter logic [63:0] MEM_BASE     = 64'h4_0000_0000,
    parameter int unsigned MEM_OFF_W    = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [ADDR_W-1:0] offset
);

    localparam logic [63:0] MEM_SPAN = 64'd1 << MEM_OFF_W;

    // Base address of window k (0 ctrl, 1 cfg address, 2 io, 3 data).
    function automatic logic [ADDR_W-1:0] wbase(input int k);
        case (k)
            0:       wbase = ADDR_W'(SPECIAL_BASE + CTRL_OFS);
            1:       wbase = ADDR_W'(SPECIAL_BASE + CFGA_OFS);
            2:       wbase = ADDR_W'(SPECIAL_BASE + IO_OFS);
            default: wbase = ADDR_W'(MEM_BASE);
        endcase
    endfunction

    // Byte span of window k.
    function automatic logic [ADDR_W:0] wspan(input int k);
        case (k)
            0:       wspan = (ADDR_W+1)'(CTRL_SPAN);
            1:       wspan = (ADDR_W+1)'(CFGA_SPAN);
            2:       wspan = (ADDR_W+1)'(IO_SPAN);
            default: wspan = (ADDR_W+1)'(MEM_SPAN);
        endcase
    endfunction

    logic [NUM_WIN-1:0] hit;
    logic [ADDR_W-1:0]  woff [NUM_WIN];

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        assign woff[k] = addr - wbase(k);
        assign hit[k]  = (addr >= wbase(k)) && ({1'b0, woff[k]} < wspan(k));
    end

    // Turn the hit vector into a window code and select its offset.
    always_comb begin
        win    = WIN_NONE;
        offset = '0;
        if (hit[0]) begin
            win    = WIN_CTRL;
            offset = woff[0];
        end else if (hit[1]) begin
            win    = WIN_CFGA;
            offset = woff[1];
        end else if (hit[2]) begin
            win    = WIN_IO;
            offset = woff[2];
        end else if (hit[3]) begin
            win    = WIN_MEM;
            offset = woff[3];
        end
    end

    // R7: the windows must never overlap.
    p_win_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/pcihost_cfgaddr_reg.sv
// Configuration-address register. On a write it converts a one-hot device
// select into bus/devfn/register form with an enable bit. It continuously
// rebuilds the one-hot form for reads. Assumes a 32-bit data path.
module pcihost_cfgaddr_reg
    import pcihost_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] stored,
    output logic [31:0] rd_word
);

    // Lowest set bit from SEL_LO upward; 32 when none is set.
    function automatic logic [5:0] low_sel(input logic [31:0] v);
        logic [5:0] idx;
        idx = 6'd32;
        for (int b = 31; b >= int'(SEL_LO); b--) begin
            if (v[b]) idx = 6'(b);
        end
        return idx;
    endfunction

    logic [5:0]  sel_idx;
    logic [31:0] enc;
    logic [7:0]  devfn;
    logic [31:0] unused_hi;

    // Build the compact stored form from the written word.
    always_comb begin
        sel_idx = low_sel(wdata);
        enc     = (32'd1 << EN_BIT) | (wdata & REG_MASK) | (32'(sel_idx) << SEL_LO);
    end

    // Hold the configuration address; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     stored <= '0;
        else if (wr_en) stored <= enc;
    end

    // Rebuild the one-hot read view from the stored devfn and register bits.
    always_comb begin
        devfn   = stored[15:8];
        rd_word = (32'd1 << devfn[7:3]) | {21'd0, devfn[2:0], 8'd0} | {24'd0, stored[7:2], 2'b00};
    end

    assign unused_hi = {stored[31:16], 16'd0};

    // R6: the register changes only when written.
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stored));
    // R2: a write always sets the enable bit.
    p_cfg_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> stored[EN_BIT]);
    // R2: the two low bits never hold data.
    p_cfg_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (stored[1:0] == 2'b00));

endmodule

// File: rtl/pcihost_irq_map.sv
// Interrupt line mapper. From a device's devfn and pin it gives the line it
// drives on the primary bus and on a secondary bus. Assumes pin is 0..3.
module pcihost_irq_map (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] devfn,
    input  logic [1:0] pin,
    output logic [4:0] pri_idx,
    output logic [4:0] sec_idx
);

    logic unused_devfn;

    // Secondary: four lines per slot chosen by devfn bits 4..3.
    // Primary: odd functions take the upper block of 16 lines.
    always_comb begin
        sec_idx = {1'b0, devfn[4:3], 2'b00} + {3'b000, pin};
        pri_idx = {devfn[0], 2'b00, pin};
    end

    assign unused_devfn = ^{devfn[7:5], devfn[2:1]};

    // R12: secondary lines stay within the first 16.
    p_sec_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        sec_idx < 5'd16);
    // R13: primary lines stay within two blocks of four.
    p_pri_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_idx[3:2] == 2'b00));

endmodule

// File: rtl/pcihost_cfg_front.sv
// PCI host configuration front end (top). Decodes single-cycle CPU requests
// into windows and forwards I/O and data-window accesses. It holds the
// configuration-address register and maps device interrupts to lines.
// Assumes one request at a time; all responses come one cycle later.
module pcihost_cfg_front
    import pcihost_pkg::*;
#(
    parameter int unsigned ADDR_W       = 36,
    parameter logic [63:0] SPECIAL_BASE = 64'h1_FE00_0000,
    parameter logic [63:0] MEM_BASE     = 64'h4_0000_0000,
    parameter int unsigned MEM_OFF_W    = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rd_valid,
    output logic [31:0]          rd_data,
    output logic [31:0]          cfg_addr,
    output logic                 io_valid,
    output logic                 io_write,
    output logic [1:0]           io_size,
    output logic [15:0]          io_port,
    output logic [31:0]          io_wdata,
    output logic                 mem_valid,
    output logic                 mem_write,
    output logic [1:0]           mem_size,
    output logic [MEM_OFF_W-1:0] mem_offset,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          fwd_rdata,
    input  logic [7:0]           irq_devfn,
    input  logic [1:0]           irq_pin,
    output logic [4:0]           irq_pri_idx,
    output logic [4:0]           irq_sec_idx
);

    win_e              win;
    logic [ADDR_W-1:0] woffset;
    logic [31:0]       cfg_rd;
    logic              is_rd;
    logic              cfg_wr;
    logic              go_io;
    logic              go_mem;
    logic              rd_fwd_q;
    logic [31:0]       rd_data_q;
    logic              unused_off;

    pcihost_win_decode #(
        .ADDR_W       (ADDR_W),
        .SPECIAL_BASE (SPECIAL_BASE),
        .MEM_BASE     (MEM_BASE),
        .MEM_OFF_W    (MEM_OFF_W)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (req_addr),
        .win    (win),
        .offset (woffset)
    );

    pcihost_cfgaddr_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (req_wdata),
        .stored  (cfg_addr),
        .rd_word (cfg_rd)
    );

    pcihost_irq_map u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .devfn   (irq_devfn),
        .pin     (irq_pin),
        .pri_idx (irq_pri_idx),
        .sec_idx (irq_sec_idx)
    );

    // Request qualifiers per window; data window gated by the enable bit.
    always_comb begin
        is_rd  = req_valid && !req_write;
        cfg_wr = req_valid && req_write && (win == WIN_CFGA);
        go_io  = req_valid && (win == WIN_IO);
        go_mem = req_valid && (win == WIN_MEM) && cfg_addr[EN_BIT];
    end

    // Register the read response: source select and locally produced data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_fwd_q  <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_valid  <= is_rd;
            rd_fwd_q  <= is_rd && (go_io || go_mem);
            rd_data_q <= (is_rd && (win == WIN_CFGA)) ? cfg_rd : '0;
        end
    end

    // Register the I/O window forward request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_valid <= 1'b0;
            io_write <= 1'b0;
            io_size  <= '0;
            io_port  <= '0;
            io_wdata <= '0;
        end else begin
            io_valid <= go_io;
            if (go_io) begin
                io_write <= req_write;
                io_size  <= req_size;
                io_port  <= req_addr[15:0];
                io_wdata <= req_wdata;
            end
        end
    end

    // Register the data window forward request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid  <= 1'b0;
            mem_write  <= 1'b0;
            mem_size   <= '0;
            mem_offset <= '0;
            mem_wdata  <= '0;
        end else begin
            mem_valid <= go_mem;
            if (go_mem) begin
                mem_write  <= req_write;
                mem_size   <= req_size;
                mem_offset <= woffset[MEM_OFF_W-1:0];
                mem_wdata  <= req_wdata;
            end
        end
    end

    // Forwarded reads take the target's data in the response cycle.
    assign rd_data = rd_fwd_q ? fwd_rdata : rd_data_q;

    assign unused_off = ^woffset;

    // R11: every read is answered in the next cycle.
    p_rdv_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);
    // R11: no response without a read.
    p_rdv_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);
    // R9: data-window forwards only with configuration enabled.
    p_mem_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> cfg_addr[EN_BIT]);
    // R8: the port number is the low 16 request address bits.
    p_io_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> (io_port == $past(req_addr[15:0])));
    // R10: unmapped accesses forward nothing and read zero.
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && win == WIN_NONE) |=> (!io_valid && !mem_valid && rd_data == 32'd0));

endmodule

// File: tb/sim_pcihost_cfg_front.sv
`timescale 1ns/1ps
module sim_pcihost_cfg_front;

    localparam int unsigned AW = 36;
    localparam logic [AW-1:0] SB   = 36'h1_FE00_0000;
    localparam logic [AW-1:0] MB   = 36'h4_0000_0000;
    localparam logic [AW-1:0] A_CT = SB + 36'h2000;
    localparam logic [AW-1:0] A_CF = SB + 36'h100_0000;
    localparam logic [AW-1:0] A_IO = SB + 36'h200_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data, cfg_addr;
    logic          io_valid, io_write;
    logic [1:0]    io_size;
    logic [15:0]   io_port;
    logic [31:0]   io_wdata;
    logic          mem_valid, mem_write;
    logic [1:0]    mem_size;
    logic [27:0]   mem_offset;
    logic [31:0]   mem_wdata;
    logic [31:0]   fwd_rdata = '0;
    logic [7:0]    irq_devfn = '0;
    logic [1:0]    irq_pin = '0;
    logic [4:0]    irq_pri_idx, irq_sec_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model = '0;

    always #4 clk = ~clk;

    pcihost_cfg_front u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .cfg_addr(cfg_addr),
        .io_valid(io_valid), .io_write(io_write), .io_size(io_size),
        .io_port(io_port), .io_wdata(io_wdata), .mem_valid(mem_valid),
        .mem_write(mem_write), .mem_size(mem_size), .mem_offset(mem_offset),
        .mem_wdata(mem_wdata), .fwd_rdata(fwd_rdata), .irq_devfn(irq_devfn),
        .irq_pin(irq_pin), .irq_pri_idx(irq_pri_idx), .irq_sec_idx(irq_sec_idx)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 none, 1 ctrl, 2 cfg address, 3 io, 4 data
    function automatic int classify(input logic [AW-1:0] a);
        if (a >= A_CT && a < A_CT + 36'h40)      return 1;
        if (a >= A_CF && a < A_CF + 36'h10)      return 2;
        if (a >= A_IO && a < A_IO + 36'h1_0000)  return 3;
        if (a >= MB   && a < MB + 36'h1000_0000) return 4;
        return 0;
    endfunction

    function automatic logic [31:0] enc(input logic [31:0] v);
        int i = 32;
        for (int b = 31; b >= 11; b--) if (v[b]) i = b;
        return 32'h1_0000 | (v & 32'h7FC) | (32'(i) << 11);
    endfunction

    function automatic logic [31:0] dec(input logic [31:0] s);
        logic [7:0] df = s[15:8];
        return (32'd1 << df[7:3]) | (32'(df[2:0]) << 8) | (s & 32'hFC);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        check(cfg_addr == 0, "R1 cfg_addr", cfg_addr, 0);
        check(!rd_valid && !io_valid && !mem_valid, "R1 strobes",
              {rd_valid, io_valid, mem_valid}, 0);
    endtask

    task automatic access(input bit wr, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd);
        int k = classify(a);
        logic [31:0] fr = $urandom;
        logic [31:0] exp_rd = 32'd0;
        bit exp_io = (k == 3);
        bit exp_mem = (k == 4) && model[16];
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a;
        req_wdata = wd; fwd_rdata = fr;
        if (k == 2) exp_rd = dec(model);
        if (exp_io || exp_mem) exp_rd = fr;
        if (wr && k == 2) model = enc(wd);
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_valid == !wr, "R11 rd_valid", rd_valid, !wr);
        if (!wr) check(rd_data == exp_rd, (k == 2) ? "R4 read" : (k == 1) ? "R6 ctrl read" :
                       (k == 0) ? "R10 unmapped read" : (k == 4) ? "R9 data read" : "R11 fwd read",
                       rd_data, exp_rd);
        check(io_valid == exp_io, "R8 io_valid", io_valid, exp_io);
        check(mem_valid == exp_mem, "R9 mem_valid", mem_valid, exp_mem);
        if (exp_io) check(io_port == a[15:0] && io_size == sz && io_write == wr &&
                          (!wr || io_wdata == wd), "R8 io fields", {io_port, io_size}, {a[15:0], sz});
        if (exp_mem) check(mem_offset == 28'(a - MB) && mem_size == sz && mem_write == wr,
                           "R9 mem offset", mem_offset, 28'(a - MB));
        check(cfg_addr == model, (k == 2) ? "R2 stored" : "R10 cfg unchanged", cfg_addr, model);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // R9: data window closed before any configuration write
        access(0, 2, MB + 36'h40, 0);
        access(1, 2, MB + 36'h80, 32'h1234);

        // R3: no select bit -> index 32
        access(1, 2, A_CF, 32'h0000_0104);
        check(cfg_addr == 32'h0001_0104, "R3 none set", cfg_addr, 32'h0001_0104);
        access(0, 2, A_CF, 0);
        // R3: highest candidate bit
        access(1, 2, A_CF + 36'h4, 32'h8000_0000);
        check(cfg_addr == 32'h0001_F800, "R3 bit31", cfg_addr, 32'h0001_F800);
        // R5: byte write still takes full value
        access(1, 0, A_CF + 36'hF, 32'hFFFF_FFFF);
        check(cfg_addr == 32'h0001_5FFC, "R5 byte write", cfg_addr, 32'h0001_5FFC);
        access(0, 1, A_CF, 0);

        // R6/R7 control window edges and neighbours
        access(1, 2, A_CT, 32'hFFFF_FFFF);
        access(0, 2, A_CT + 36'h3F, 0);
        access(0, 2, A_CT + 36'h40, 0);
        access(1, 2, A_CF + 36'h10, 32'h0000_0800);
        // R7 io and data window edges
        access(0, 2, A_IO, 0);
        access(1, 1, A_IO + 36'hFFFF, 32'hA5A5);
        access(0, 2, A_IO + 36'h1_0000, 0);
        access(0, 0, MB + 36'h0FFF_FFFF, 0);
        access(0, 0, MB + 36'h1000_0000, 0);
        access(0, 0, MB - 36'h1, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom % 6;
            bit wr = $urandom % 2;
            logic [1:0] sz = 2'($urandom % 3);
            logic [AW-1:0] a;
            case (kind)
                0: a = A_CT + AW'($urandom % 64);
                1: a = A_CF + AW'($urandom % 16);
                2: a = A_IO + AW'($urandom % 65536);
                3: a = MB + AW'($urandom % 32'h1000_0000);
                4: a = {4'($urandom), 32'($urandom)};
                default: a = A_CF;
            endcase
            access(wr, sz, a, $urandom);
            if (n == 200) begin
                do_reset();
                access(0, 2, MB, 0);
            end
        end

        // R12 / R13 interrupt mapping
        for (int n = 0; n < 64; n++) begin
            logic [7:0] df = 8'($urandom);
            logic [1:0] pn = 2'($urandom);
            logic [4:0] es, ep;
            if (n < 4) begin df = (n == 0) ? 8'h00 : (n == 1) ? 8'h19 : (n == 2) ? 8'hFF : 8'h18; pn = 2'(n); end
            @(negedge clk);
            irq_devfn = df; irq_pin = pn;
            es = 5'(((df & 8'h18) >> 1) + 8'(pn));
            ep = 5'(pn) + (df[0] ? 5'd16 : 5'd0);
            #1;
            check(irq_sec_idx == es, "R12 secondary", irq_sec_idx, es);
            check(irq_pri_idx == ep, "R13 primary", irq_pri_idx, ep);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule